// File: doc/BRIEF.md
# Tree-Structured Leading-One Detector

This block takes a request vector and reports the position of the winning set bit as a binary number, together with a flag that says whether any bit was set at all. A parameter chooses the winner. It is either the set bit with the highest position or the set bit with the lowest position, and every part of the tree follows the same rule. Typical uses are interrupt arbitration, normalisation shift counts and match-line resolution in search memories.

The block is not a flat scan across the vector. It is a tree of small radix-way selectors. The bottom row looks at groups of raw bits. Each higher node receives the any-set flags and sub-positions of its children. It picks the winning child with the same small selector, then joins the child number (upper bits) to that child's sub-position (lower bits). Logic depth grows with the logarithm of the width in base radix, and area grows linearly with the width. When the width is not a power of the radix, the vector is extended with constant zeros up to the next power. A register row can be placed after every tree level, which gives one result per clock at a latency equal to the number of levels.

Top module: `prio_tree_encoder`

## Requirements
- R1: `valid_o` is 1 exactly when at least one bit of the request vector (as presented LEVELS cycles earlier when pipelined, or in the same cycle when not) is 1.
- R2: When `valid_o` is 1, bit `index_o` of that request vector is 1.
- R3: When `valid_o` is 0, `index_o` is all zeros.
- R4: With HIGH_FIRST=1, `index_o` is the highest set position. For a 4-bit group, 0001 gives 0, 001x gives 1, 01xx gives 2 and 1xxx gives 3.
- R5: With HIGH_FIRST=0, `index_o` is the lowest set position.
- R6: For a width that is not a power of RADIX, the zero padding never wins: `index_o` is always below WIDTH, and a lone top bit (position WIDTH-1) gives WIDTH-1.
- R7: With PIPELINED=0, the outputs follow `req_i` within the same cycle, with no clock edge.
- R8: With PIPELINED=1, every cycle's request produces its result exactly LEVELS clock edges later, where LEVELS = ceil(log_RADIX WIDTH), and a new request is accepted every cycle.
- R9: With PIPELINED=1, a synchronous `rst` clears the output to valid 0, index 0. After release, valid stays 0 until a request has passed through all LEVELS stages.
- R10: Any power-of-two RADIX of 2 or more gives the same position. `index_o` is LEVELS*log2(RADIX) bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional level registers |
| rst | input | 1 | Synchronous active-high reset of the level registers |
| req_i | input | WIDTH | Request vector |
| valid_o | output | 1 | Some request bit is set |
| index_o | output | IDX_W | Binary position of the winning bit, zero when none |

## Verification
The checker assumes that `req_i` is stable around each rising edge and that `rst` is high at the first edge. It compares each output with a copy of the input delayed inside the checker by the tree latency. That copy is cleared by the same reset, so it assumes no result is expected from requests made while reset is high. The bench changes `req_i` and `rst` only on falling edges and holds reset at start-up, and it checks the comparison results in the half-cycle away from the active edge.

// File: rtl/prio_tree_pkg.sv
package prio_tree_pkg;

   // number of radix-way levels needed to cover the given width (at least one)
   function automatic int tree_levels(input int width, input int radix);
      int  lv;
      longint span;
      lv   = 1;
      span = radix;
      while (span < width) begin
         span = span * radix;
         lv   = lv + 1;
      end
      return lv;
   endfunction

   // radix raised to a level count: the number of raw bits covered
   function automatic int tree_span(input int radix, input int levels);
      int s;
      s = 1;
      for (int i = 0; i < levels; i++) s = s * radix;
      return s;
   endfunction

endpackage

// File: rtl/prio_leaf.sv
// Radix-way priority selector on a group of flags.
module prio_leaf #(
   parameter int WAYS       = 4,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int SEL_W     = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  req_i,
   output logic             any_o,
   output logic [SEL_W-1:0] sel_o
);

   assign any_o = |req_i;

   if (HIGH_FIRST) begin : g_high
      always_comb begin
         sel_o = '0;
         for (int w = 0; w < WAYS; w++)
            if (req_i[w]) sel_o = SEL_W'(w);
      end
   end else begin : g_low
      always_comb begin
         sel_o = '0;
         for (int w = WAYS - 1; w >= 0; w--)
            if (req_i[w]) sel_o = SEL_W'(w);
      end
   end

endmodule

// File: rtl/prio_merge.sv
// One inner tree node: picks the first valid child, appends its sub-position.
module prio_merge #(
   parameter int WAYS       = 4,
   parameter int SUB_W      = 2,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int SEL_W     = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]             sub_v_i,
   input  logic [WAYS-1:0][SUB_W-1:0]  sub_i_i,
   output logic                        v_o,
   output logic [SEL_W+SUB_W-1:0]      idx_o
);

   logic [SEL_W-1:0] child;

   prio_leaf #(
      .WAYS       (WAYS),
      .HIGH_FIRST (HIGH_FIRST)
   ) u_pick (
      .req_i (sub_v_i),
      .any_o (v_o),
      .sel_o (child)
   );

   // with no valid child, child is 0 and child 0 carries an all-zero index
   assign idx_o = {child, sub_i_i[child]};

endmodule

// File: rtl/prio_stage.sv
// Optional register row between tree levels.
module prio_stage #(
   parameter int NODES      = 4,
   parameter int IDX_W      = 2,
   parameter bit REGISTERED = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [NODES-1:0]            d_v,
   input  logic [NODES-1:0][IDX_W-1:0] d_i,
   output logic [NODES-1:0]            q_v,
   output logic [NODES-1:0][IDX_W-1:0] q_i
);

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            q_v <= '0;
            q_i <= '0;
         end else begin
            q_v <= d_v;
            q_i <= d_i;
         end
      end
   end else begin : g_wire
      assign q_v = d_v;
      assign q_i = d_i;
   end

endmodule

// File: rtl/prio_tree_encoder.sv
module prio_tree_encoder
   import prio_tree_pkg::*;
#(
   parameter int WIDTH      = 24,
   parameter int RADIX      = 4,
   parameter bit HIGH_FIRST = 1'b1,
   parameter bit PIPELINED  = 1'b1,
   localparam int SEL_W     = $clog2(RADIX),
   localparam int LEVELS    = tree_levels(WIDTH, RADIX),
   localparam int IDX_W     = LEVELS * SEL_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] req_i,
   output logic             valid_o,
   output logic [IDX_W-1:0] index_o
);

   localparam int SPAN = tree_span(RADIX, LEVELS);

   if (RADIX < 2 || (1 << SEL_W) != RADIX) begin : g_bad_radix
      $error("prio_tree_encoder: RADIX must be a power of two, at least 2");
   end
   if (WIDTH < 2) begin : g_bad_width
      $error("prio_tree_encoder: WIDTH must be at least 2");
   end

   // zero extension up to a full power of RADIX; padded bits never win
   logic [SPAN-1:0] padded;
   always_comb begin
      padded             = '0;
      padded[WIDTH-1:0]  = req_i;
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int NODES = SPAN / tree_span(RADIX, l + 1);
      localparam int OW    = (l + 1) * SEL_W;

      logic [NODES-1:0]         node_v;
      logic [NODES-1:0][OW-1:0] node_i;
      logic [NODES-1:0]         q_v;
      logic [NODES-1:0][OW-1:0] q_i;

      for (genvar n = 0; n < NODES; n++) begin : g_node
         if (l == 0) begin : g_leaf
            logic [SEL_W-1:0] sel;
            prio_leaf #(
               .WAYS       (RADIX),
               .HIGH_FIRST (HIGH_FIRST)
            ) u_leaf (
               .req_i (padded[n*RADIX +: RADIX]),
               .any_o (node_v[n]),
               .sel_o (sel)
            );
            assign node_i[n] = sel;
         end else begin : g_merge
            prio_merge #(
               .WAYS       (RADIX),
               .SUB_W      (l * SEL_W),
               .HIGH_FIRST (HIGH_FIRST)
            ) u_merge (
               .sub_v_i (g_lvl[l-1].q_v[n*RADIX +: RADIX]),
               .sub_i_i (g_lvl[l-1].q_i[n*RADIX +: RADIX]),
               .v_o     (node_v[n]),
               .idx_o   (node_i[n])
            );
         end
      end

      prio_stage #(
         .NODES      (NODES),
         .IDX_W      (OW),
         .REGISTERED (PIPELINED)
      ) u_stage (
         .clk (clk),
         .rst (rst),
         .d_v (node_v),
         .d_i (node_i),
         .q_v (q_v),
         .q_i (q_i)
      );
   end

   assign valid_o = g_lvl[LEVELS-1].q_v[0];
   assign index_o = g_lvl[LEVELS-1].q_i[0];

endmodule

// File: rtl/prio_tree_encoder_chk.sv
module prio_tree_encoder_chk
   import prio_tree_pkg::*;
#(
   parameter int WIDTH      = 24,
   parameter int RADIX      = 4,
   parameter bit HIGH_FIRST = 1'b1,
   parameter bit PIPELINED  = 1'b1,
   parameter int IDX_W      = 6
) (
   input logic             clk,
   input logic             rst,
   input logic [WIDTH-1:0] req_i,
   input logic             valid_o,
   input logic [IDX_W-1:0] index_o
);

   localparam int LEVELS = tree_levels(WIDTH, RADIX);

   // request vector aligned with the output it produced
   logic [WIDTH-1:0] seen;

   if (PIPELINED) begin : g_delay
      logic [LEVELS-1:0][WIDTH-1:0] sh;
      always_ff @(posedge clk) begin
         if (rst) begin
            sh <= '0;
         end else begin
            sh[0] <= req_i;
            for (int s = 1; s < LEVELS; s++) sh[s] <= sh[s-1];
         end
      end
      assign seen = sh[LEVELS-1];
   end else begin : g_direct
      assign seen = req_i;
   end

   p_valid_any_r1: assert property (@(posedge clk) disable iff (rst)
      valid_o == (|seen));

   p_hit_is_set_r2: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> 1'(seen >> index_o));

   p_idle_zero_r3: assert property (@(posedge clk) disable iff (rst)
      !valid_o |-> (index_o == '0));

   p_in_range_r6: assert property (@(posedge clk) disable iff (rst)
      valid_o |-> (32'(index_o) < WIDTH));

   if (HIGH_FIRST) begin : g_hi
      p_highest_wins_r4: assert property (@(posedge clk) disable iff (rst)
         valid_o |-> ((seen >> index_o) == WIDTH'(1)));
   end else begin : g_lo
      p_lowest_wins_r5: assert property (@(posedge clk) disable iff (rst)
         valid_o |-> ((seen & ((WIDTH'(1) << index_o) - WIDTH'(1))) == '0));
   end

endmodule

bind prio_tree_encoder prio_tree_encoder_chk #(
   .WIDTH      (WIDTH),
   .RADIX      (RADIX),
   .HIGH_FIRST (HIGH_FIRST),
   .PIPELINED  (PIPELINED),
   .IDX_W      (IDX_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .req_i   (req_i),
   .valid_o (valid_o),
   .index_o (index_o)
);

// File: tb/test_prio_tree_encoder.sv
`timescale 1ns/1ps
module test_prio_tree_encoder;

   localparam int W   = 24;
   localparam int LAT = 3;   // ceil(log4 24)

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [W-1:0]  req = '0;
   logic          a_v, b_v, c_v;
   logic [5:0]    a_i, b_i;
   logic [4:0]    c_i;
   int            n_run  = 0;
   int            n_fail = 0;

   always #2 clk = ~clk;   // 250 MHz

   // high-first, combinational
   prio_tree_encoder #(.WIDTH(W), .RADIX(4), .HIGH_FIRST(1'b1), .PIPELINED(1'b0)) i_prio_tree_encoder (
      .clk(clk), .rst(rst), .req_i(req), .valid_o(a_v), .index_o(a_i));
   // low-first, pipelined
   prio_tree_encoder #(.WIDTH(W), .RADIX(4), .HIGH_FIRST(1'b0), .PIPELINED(1'b1)) i_prio_tree_encoder_pipe (
      .clk(clk), .rst(rst), .req_i(req), .valid_o(b_v), .index_o(b_i));
   // high-first, radix 2, combinational
   prio_tree_encoder #(.WIDTH(W), .RADIX(2), .HIGH_FIRST(1'b1), .PIPELINED(1'b0)) i_prio_tree_encoder_r2 (
      .clk(clk), .rst(rst), .req_i(req), .valid_o(c_v), .index_o(c_i));

   function automatic int hi_pos(input logic [W-1:0] v);
      int p = -1;
      for (int k = 0; k < W; k++) if (v[k]) p = k;
      return p;
   endfunction

   function automatic int lo_pos(input logic [W-1:0] v);
      int p = -1;
      for (int k = W - 1; k >= 0; k--) if (v[k]) p = k;
      return p;
   endfunction

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // combinational instances, current req
   task automatic check_comb(input logic [W-1:0] v);
      int h = hi_pos(v);
      check("R1", "comb valid", int'(a_v), int'(h >= 0));
      check(h >= 0 ? "R4" : "R3", "comb index", int'(a_i), h < 0 ? 0 : h);
      check("R10", "radix-2 valid", int'(c_v), int'(h >= 0));
      check("R10", "radix-2 index", int'(c_i), h < 0 ? 0 : h);
   endtask

   // pipelined instance against a past request
   task automatic check_pipe(input logic [W-1:0] v, input string tag);
      int l = lo_pos(v);
      check(tag, "pipe valid", int'(b_v), int'(l >= 0));
      check(l >= 0 ? tag : "R3", "pipe index", int'(b_i), l < 0 ? 0 : l);
   endtask

   // drive at a falling edge, let the pipe fill, check everything
   task automatic apply(input logic [W-1:0] v);
      @(negedge clk);
      req = v;
      repeat (LAT) @(negedge clk);
      check_comb(v);
      check_pipe(v, "R5");
   endtask

   task automatic t_reset;
      req = '1;
      repeat (3) @(negedge clk);
      check("R9", "pipe valid in reset", int'(b_v), 0);
      check("R9", "pipe index in reset", int'(b_i), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "pipe valid 1 edge after release", int'(b_v), 0);
      @(negedge clk);
      check("R9", "pipe valid 2 edges after release", int'(b_v), 0);
      @(negedge clk);
      check("R9", "pipe valid after LEVELS edges", int'(b_v), 1);
      check("R9", "pipe index after LEVELS edges", int'(b_i), 0);
   endtask

   task automatic t_idle;
      apply('0);
      check("R3", "comb index when idle", int'(a_i), 0);
   endtask

   task automatic t_leaf_table;
      apply(24'h000001);
      apply(24'h000003);
      apply(24'h000006);
      apply(24'h00000D);
      apply(24'h00000F);
      apply(24'h000008);
   endtask

   task automatic t_walk_single;
      for (int k = 0; k < W; k++) apply(W'(1) << k);
      apply(W'(1) << (W - 1));
      check("R6", "top real bit index", int'(a_i), W - 1);
      check("R6", "top real bit pipe index", int'(b_i), W - 1);
   endtask

   task automatic t_patterns;
      logic [W-1:0] pats [6] = '{24'hFFFFFF, 24'h800001, 24'h010100, 24'h5A0000, 24'h000F00, 24'h2400A0};
      foreach (pats[p]) begin
         apply(pats[p]);
         check("R2", "comb index names a set bit", int'(pats[p][a_i]), 1);
         check("R2", "pipe index names a set bit", int'(pats[p][b_i]), 1);
      end
   endtask

   task automatic t_comb_same_cycle;
      @(negedge clk);
      req = 24'h004010;
      #1;
      check("R7", "comb index before any edge", int'(a_i), 14);
      req = 24'h000000;
      #0.5;
      check("R7", "comb valid drop before any edge", int'(a_v), 0);
   endtask

   task automatic t_stream;
      logic [W-1:0] hist [64];
      logic [31:0]  s = 32'h1234_5678;
      for (int k = 0; k < 64; k++) begin
         s = s ^ (s << 13);
         s = s ^ (s >> 17);
         s = s ^ (s << 5);
         hist[k] = (k % 7 == 3) ? '0 : (s[23:0] & (k[0] ? s[31:8] : 24'hF0F0F0));
      end
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         if (k >= LAT) check_pipe(hist[k-LAT], "R8");
         req = hist[k];
      end
   endtask

   task automatic t_mid_reset;
      apply(24'h030000);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check("R9", "pipe valid after mid-run reset", int'(b_v), 0);
      check("R9", "pipe index after mid-run reset", int'(b_i), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "pipe still empty after release", int'(b_v), 0);
      repeat (LAT - 1) @(negedge clk);
      check_pipe(24'h030000, "R9");
   endtask

   initial begin : main
      t_reset();
      t_idle();
      t_leaf_table();
      t_walk_single();
      t_patterns();
      t_comb_same_cycle();
      t_stream();
      t_mid_reset();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule